// File: doc/BRIEF.md
# Window Pixel Transfer Sequencer

This block takes a rectangular update window and steers a stream of 16-bit host words into a frame buffer. The window is given as inclusive start and end coordinates in X and Y, together with a bytes-per-pixel value and a source selector. When a transfer is armed, the block checks the window, works out its width, height and length in 16-bit words, and then tags each accepted word with the frame-buffer address of the row it belongs to and the byte offset inside that row.

A transfer is armed either by a write to the source-select strobe or, when nothing is outstanding, by the first data word itself. The final word of the window raises a one-cycle completion pulse. Each completed window is folded into a dirty rectangle that a display refresh process reads, clears back to empty once it has consumed it, or forces to cover the whole display.

Pixel format conversion, rotation and the memory itself are outside the block. The frame buffer is addressed in pixels, row-major, with a row pitch equal to the display width.

Top module: `win_xfer_seq`

## Requirements
- R1: After reset busy, done and wrEn are 0, and the dirty rectangle is empty: dirtyMinX = dispWidth, dirtyMaxX = 0, dirtyMinY = dispHeight, dirtyMaxY = 0.
- R2: Setup fails, and no transfer is armed, when cfgSource is greater than 3, when cfgBpp is 0, when cfgXEnd < cfgXStart or cfgYEnd < cfgYStart, or when cfgBpp × width is below 2; a data word that arrives while idle under such a setting produces no write.
- R3: With width = cfgXEnd − cfgXStart + 1 and height = cfgYEnd − cfgYStart + 1, a transfer takes exactly floor(cfgBpp × width × height / 2) accepted words.
- R4: A srcSelWr pulse with a valid setting (re)starts a transfer with the full word count, discarding any words still outstanding; a dataWr while idle runs setup first and, if it succeeds, counts as the first word of the new transfer.
- R5: Each accepted word gives wrEn = 1 in the following cycle with wrData equal to the word, wrByteOff = 2k − r × cfgBpp × width for the k-th word (from 0) of the transfer, and wrRowAddr = (cfgYStart + r) × dispWidth + cfgXStart, where r is the number of whole rows of cfgBpp × width bytes that precede that word's first byte.
- R6: done is high for one cycle, in the same cycle as the write of the last word of a transfer.
- R7: In the cycle after done, the dirty rectangle has taken the minimum with the window start in X and Y and the maximum with start plus width (X) and start plus height (Y).
- R8: A refreshAck pulse empties the dirty rectangle to the R1 values in the next cycle; if done is high in the same cycle, that window is merged into the empty rectangle.
- R9: An invalidate pulse sets the dirty rectangle to 0, dispWidth, 0, dispHeight in the next cycle, taking priority over refreshAck and a merge.
- R10: busy is high exactly while accepted words of an armed transfer are still outstanding; in a cycle with neither srcSelWr nor dataWr it does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgXStart | input | CW | Window first column |
| cfgXEnd | input | CW | Window last column (inclusive) |
| cfgYStart | input | CW | Window first row |
| cfgYEnd | input | CW | Window last row (inclusive) |
| cfgBpp | input | BPW | Bytes per pixel |
| cfgSource | input | 3 | Source selector, valid 0 to 3 |
| dispWidth | input | CW+1 | Display width in pixels, also the row pitch |
| dispHeight | input | CW+1 | Display height in rows |
| srcSelWr | input | 1 | Source-select write strobe; runs setup |
| dataWr | input | 1 | Data word strobe |
| dataIn | input | 16 | Data word |
| refreshAck | input | 1 | Refresh consumed the dirty rectangle |
| invalidate | input | 1 | Mark the whole display dirty |
| wrEn | output | 1 | Frame-buffer write strobe |
| wrData | output | 16 | Word to write |
| wrRowAddr | output | 2*CW+1 | Pixel address of the start of the word's row |
| wrByteOff | output | BPW+CW+1 | Byte offset of the word inside its row |
| busy | output | 1 | Words of a transfer outstanding |
| done | output | 1 | Last word of a transfer written |
| dirtyMinX | output | CW+1 | Dirty rectangle left edge |
| dirtyMaxX | output | CW+1 | Dirty rectangle right edge (exclusive) |
| dirtyMinY | output | CW+1 | Dirty rectangle top edge |
| dirtyMaxY | output | CW+1 | Dirty rectangle bottom edge (exclusive) |

## Verification
The checks assume that srcSelWr and dataWr never rise in the same cycle, that the display dimensions are nonzero and fixed between resets, and that the window settings only change while no transfer is outstanding, since they are captured at setup. The stimulus drives the two strobes from separate tasks that never overlap, holds dispWidth and dispHeight constant, and rewrites the window only between transfers. Under those limits the cycle-level model in the bench can hold the captured geometry itself and compare every output on every clock.

// File: rtl/win_xfer_pkg.sv
package win_xfer_pkg;
  localparam int WORD_W = 16;

  // Strobes from the sequencing control to the datapath.
  typedef struct packed {
    logic load;    // setup succeeded, capture the window
    logic accept;  // a data word is taken this cycle
    logic commit;  // a window finished last cycle
  } xferStrobes_t;
endpackage

// File: rtl/win_xfer_ctrl.sv
module win_xfer_ctrl
  import win_xfer_pkg::*;
#(
  parameter int CW  = 10,
  parameter int BPW = 3,
  parameter int DW  = CW + 1,
  parameter int RBW = BPW + DW,
  parameter int LW  = RBW + DW - 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [CW-1:0]  cfgXStart,
  input  logic [CW-1:0]  cfgXEnd,
  input  logic [CW-1:0]  cfgYStart,
  input  logic [CW-1:0]  cfgYEnd,
  input  logic [BPW-1:0] cfgBpp,
  input  logic [2:0]     cfgSource,
  input  logic           srcSelWr,
  input  logic           dataWr,
  output xferStrobes_t   strobes,
  output logic [DW-1:0]  winWidth,
  output logic [DW-1:0]  winHeight,
  output logic [RBW-1:0] winRowBytes,
  output logic           busy,
  output logic           done
);
  localparam int TBW = RBW + DW;

  logic [TBW-1:0] totBytes;
  logic [LW-1:0]  lenWords, remain, startCnt;
  logic           setupOk, pending, load, accept;

  always_comb begin
    winWidth    = DW'({1'b0, cfgXEnd} - {1'b0, cfgXStart}) + DW'(1);
    winHeight   = DW'({1'b0, cfgYEnd} - {1'b0, cfgYStart}) + DW'(1);
    winRowBytes = RBW'(cfgBpp) * RBW'(winWidth);
    totBytes    = TBW'(winRowBytes) * TBW'(winHeight);
    lenWords    = totBytes[TBW-1:1];
  end

  assign setupOk  = (cfgSource <= 3'd3) && (cfgBpp != '0) &&
                    (cfgXEnd >= cfgXStart) && (cfgYEnd >= cfgYStart) &&
                    (winRowBytes >= RBW'(2));
  assign pending  = (remain != '0);
  assign load     = setupOk && (srcSelWr || (dataWr && !pending));
  assign accept   = dataWr && (pending || setupOk);
  assign startCnt = load ? lenWords : remain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remain <= '0;
      done   <= 1'b0;
    end else begin
      if (accept)    remain <= startCnt - LW'(1);
      else if (load) remain <= lenWords;
      done <= accept && (startCnt == LW'(1));
    end
  end

  assign busy    = pending;
  assign strobes = '{load: load, accept: accept, commit: done};
endmodule

// File: rtl/win_xfer_dp.sv
module win_xfer_dp
  import win_xfer_pkg::*;
#(
  parameter int CW  = 10,
  parameter int BPW = 3,
  parameter int DW  = CW + 1,
  parameter int RBW = BPW + DW,
  parameter int AW  = 2 * CW + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  xferStrobes_t      strobes,
  input  logic [CW-1:0]     cfgXStart,
  input  logic [CW-1:0]     cfgYStart,
  input  logic [DW-1:0]     winWidth,
  input  logic [DW-1:0]     winHeight,
  input  logic [RBW-1:0]    winRowBytes,
  input  logic [DW-1:0]     dispWidth,
  input  logic [DW-1:0]     dispHeight,
  input  logic [WORD_W-1:0] dataIn,
  input  logic              refreshAck,
  input  logic              invalidate,
  output logic              wrEn,
  output logic [WORD_W-1:0] wrData,
  output logic [AW-1:0]     wrRowAddr,
  output logic [RBW-1:0]    wrByteOff,
  output logic [DW-1:0]     dirtyMinX,
  output logic [DW-1:0]     dirtyMaxX,
  output logic [DW-1:0]     dirtyMinY,
  output logic [DW-1:0]     dirtyMaxY
);
  // captured window
  logic [CW-1:0]  xsQ, ysQ;
  logic [DW-1:0]  widQ, hgtQ, pitchQ;
  logic [RBW-1:0] rowBytesQ, offQ;
  logic [AW-1:0]  rowAddrQ;

  logic [AW-1:0]  firstRowAddr, effRowAddr;
  logic [RBW-1:0] effOff, effRowBytes, nextOff;
  logic [DW-1:0]  effPitch;
  logic           rowWrap;

  assign firstRowAddr = AW'(cfgYStart) * AW'(dispWidth) + AW'(cfgXStart);
  assign effRowAddr   = strobes.load ? firstRowAddr : rowAddrQ;
  assign effOff       = strobes.load ? '0 : offQ;
  assign effRowBytes  = strobes.load ? winRowBytes : rowBytesQ;
  assign effPitch     = strobes.load ? dispWidth : pitchQ;
  assign nextOff      = effOff + RBW'(2);
  assign rowWrap      = (nextOff >= effRowBytes);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xsQ <= '0; ysQ <= '0; widQ <= '0; hgtQ <= '0; pitchQ <= '0;
      rowBytesQ <= '0; offQ <= '0; rowAddrQ <= '0;
      wrEn <= 1'b0; wrData <= '0; wrRowAddr <= '0; wrByteOff <= '0;
    end else begin
      wrEn <= strobes.accept;
      if (strobes.load) begin
        xsQ       <= cfgXStart;
        ysQ       <= cfgYStart;
        widQ      <= winWidth;
        hgtQ      <= winHeight;
        pitchQ    <= dispWidth;
        rowBytesQ <= winRowBytes;
        offQ      <= '0;
        rowAddrQ  <= firstRowAddr;
      end
      if (strobes.accept) begin
        wrData    <= dataIn;
        wrRowAddr <= effRowAddr;
        wrByteOff <= effOff;
        offQ      <= rowWrap ? nextOff - effRowBytes : nextOff;
        rowAddrQ  <= rowWrap ? effRowAddr + AW'(effPitch) : effRowAddr;
      end
    end
  end

  // dirty rectangle: invalidate > refresh/merge
  logic [DW-1:0] winEndX, winEndY;
  logic [DW-1:0] baseMinX, baseMaxX, baseMinY, baseMaxY;
  logic [DW-1:0] nMinX, nMaxX, nMinY, nMaxY;

  assign winEndX = DW'(xsQ) + widQ;
  assign winEndY = DW'(ysQ) + hgtQ;

  always_comb begin
    baseMinX = refreshAck ? dispWidth  : dirtyMinX;
    baseMaxX = refreshAck ? '0         : dirtyMaxX;
    baseMinY = refreshAck ? dispHeight : dirtyMinY;
    baseMaxY = refreshAck ? '0         : dirtyMaxY;
    nMinX = baseMinX; nMaxX = baseMaxX; nMinY = baseMinY; nMaxY = baseMaxY;
    if (strobes.commit) begin
      if (DW'(xsQ) < baseMinX) nMinX = DW'(xsQ);
      if (winEndX > baseMaxX)  nMaxX = winEndX;
      if (DW'(ysQ) < baseMinY) nMinY = DW'(ysQ);
      if (winEndY > baseMaxY)  nMaxY = winEndY;
    end
    if (invalidate) begin
      nMinX = '0; nMaxX = dispWidth; nMinY = '0; nMaxY = dispHeight;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirtyMinX <= dispWidth;
      dirtyMaxX <= '0;
      dirtyMinY <= dispHeight;
      dirtyMaxY <= '0;
    end else begin
      dirtyMinX <= nMinX;
      dirtyMaxX <= nMaxX;
      dirtyMinY <= nMinY;
      dirtyMaxY <= nMaxY;
    end
  end
endmodule

// File: rtl/win_xfer_seq.sv
module win_xfer_seq
  import win_xfer_pkg::*;
#(
  parameter  int CW  = 10,
  parameter  int BPW = 3,
  localparam int DW  = CW + 1,
  localparam int RBW = BPW + DW,
  localparam int AW  = 2 * CW + 1,
  localparam int LW  = RBW + DW - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CW-1:0]     cfgXStart,
  input  logic [CW-1:0]     cfgXEnd,
  input  logic [CW-1:0]     cfgYStart,
  input  logic [CW-1:0]     cfgYEnd,
  input  logic [BPW-1:0]    cfgBpp,
  input  logic [2:0]        cfgSource,
  input  logic [DW-1:0]     dispWidth,
  input  logic [DW-1:0]     dispHeight,
  input  logic              srcSelWr,
  input  logic              dataWr,
  input  logic [WORD_W-1:0] dataIn,
  input  logic              refreshAck,
  input  logic              invalidate,
  output logic              wrEn,
  output logic [WORD_W-1:0] wrData,
  output logic [AW-1:0]     wrRowAddr,
  output logic [RBW-1:0]    wrByteOff,
  output logic              busy,
  output logic              done,
  output logic [DW-1:0]     dirtyMinX,
  output logic [DW-1:0]     dirtyMaxX,
  output logic [DW-1:0]     dirtyMinY,
  output logic [DW-1:0]     dirtyMaxY
);
  xferStrobes_t   strobes;
  logic [DW-1:0]  winWidth, winHeight;
  logic [RBW-1:0] winRowBytes;

  win_xfer_ctrl #(.CW(CW), .BPW(BPW), .DW(DW), .RBW(RBW), .LW(LW)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .cfgXStart(cfgXStart), .cfgXEnd(cfgXEnd),
    .cfgYStart(cfgYStart), .cfgYEnd(cfgYEnd),
    .cfgBpp(cfgBpp), .cfgSource(cfgSource),
    .srcSelWr(srcSelWr), .dataWr(dataWr),
    .strobes(strobes), .winWidth(winWidth), .winHeight(winHeight),
    .winRowBytes(winRowBytes), .busy(busy), .done(done)
  );

  win_xfer_dp #(.CW(CW), .BPW(BPW), .DW(DW), .RBW(RBW), .AW(AW)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .cfgXStart(cfgXStart), .cfgYStart(cfgYStart),
    .winWidth(winWidth), .winHeight(winHeight), .winRowBytes(winRowBytes),
    .dispWidth(dispWidth), .dispHeight(dispHeight), .dataIn(dataIn),
    .refreshAck(refreshAck), .invalidate(invalidate),
    .wrEn(wrEn), .wrData(wrData), .wrRowAddr(wrRowAddr), .wrByteOff(wrByteOff),
    .dirtyMinX(dirtyMinX), .dirtyMaxX(dirtyMaxX),
    .dirtyMinY(dirtyMinY), .dirtyMaxY(dirtyMaxY)
  );
endmodule

// File: rtl/win_xfer_seq_chk.sv
module win_xfer_seq_chk #(
  parameter int CW  = 10,
  parameter int BPW = 3
) (
  input logic            clk,
  input logic            rstN,
  input logic [BPW-1:0]  cfgBpp,
  input logic [CW:0]     dispWidth,
  input logic [CW:0]     dispHeight,
  input logic            srcSelWr,
  input logic            dataWr,
  input logic            refreshAck,
  input logic            invalidate,
  input logic            wrEn,
  input logic            busy,
  input logic            done,
  input logic [CW:0]     dirtyMinX,
  input logic [CW:0]     dirtyMaxX,
  input logic [CW:0]     dirtyMinY,
  input logic [CW:0]     dirtyMaxY
);
  // Input rule behind R4: the two strobes never share a cycle.
  a_r4_exclusive_strobes: assert property (@(posedge clk) disable iff (!rstN)
    !(srcSelWr && dataWr));

  a_r2_zero_bpp_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && !busy && cfgBpp == '0) |=> !wrEn);

  a_r5_write_follows_word: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> $past(dataWr));

  a_r6_done_on_write: assert property (@(posedge clk) disable iff (!rstN)
    done |-> wrEn);

  a_r7_commit_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    (done && !invalidate) |=> (dirtyMinX < dirtyMaxX && dirtyMinY < dirtyMaxY));

  a_r8_refresh_empties: assert property (@(posedge clk) disable iff (!rstN)
    (refreshAck && !invalidate && !done) |=>
      (dirtyMaxX == '0 && dirtyMaxY == '0 &&
       dirtyMinX == $past(dispWidth) && dirtyMinY == $past(dispHeight)));

  a_r9_invalidate_full: assert property (@(posedge clk) disable iff (!rstN)
    invalidate |=> (dirtyMinX == '0 && dirtyMinY == '0 &&
                    dirtyMaxX == $past(dispWidth) && dirtyMaxY == $past(dispHeight)));

  a_r10_busy_holds_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!dataWr && !srcSelWr) |=> (busy == $past(busy)));
endmodule

bind win_xfer_seq win_xfer_seq_chk #(.CW(CW), .BPW(BPW)) chk_i (
  .clk(clk), .rstN(rstN), .cfgBpp(cfgBpp),
  .dispWidth(dispWidth), .dispHeight(dispHeight),
  .srcSelWr(srcSelWr), .dataWr(dataWr),
  .refreshAck(refreshAck), .invalidate(invalidate),
  .wrEn(wrEn), .busy(busy), .done(done),
  .dirtyMinX(dirtyMinX), .dirtyMaxX(dirtyMaxX),
  .dirtyMinY(dirtyMinY), .dirtyMaxY(dirtyMaxY)
);

// File: tb/win_xfer_seq_tb.sv
module win_xfer_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 10;
  localparam int BPW = 3;
  localparam int DISP_W = 16;
  localparam int DISP_H = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CW-1:0] cfgXStart = '0, cfgXEnd = '0, cfgYStart = '0, cfgYEnd = '0;
  logic [BPW-1:0] cfgBpp = 3'd2;
  logic [2:0] cfgSource = '0;
  logic [CW:0] dispWidth = DISP_W, dispHeight = DISP_H;
  logic srcSelWr = 1'b0, dataWr = 1'b0, refreshAck = 1'b0, invalidate = 1'b0;
  logic [15:0] dataIn = '0;
  logic wrEn, busy, done;
  logic [15:0] wrData;
  logic [2*CW:0] wrRowAddr;
  logic [BPW+CW:0] wrByteOff;
  logic [CW:0] dirtyMinX, dirtyMaxX, dirtyMinY, dirtyMaxY;

  always #(CLK_PERIOD/2) clk = ~clk;

  win_xfer_seq #(.CW(CW), .BPW(BPW)) dut_i (
    .clk(clk), .rstN(rstN),
    .cfgXStart(cfgXStart), .cfgXEnd(cfgXEnd),
    .cfgYStart(cfgYStart), .cfgYEnd(cfgYEnd),
    .cfgBpp(cfgBpp), .cfgSource(cfgSource),
    .dispWidth(dispWidth), .dispHeight(dispHeight),
    .srcSelWr(srcSelWr), .dataWr(dataWr), .dataIn(dataIn),
    .refreshAck(refreshAck), .invalidate(invalidate),
    .wrEn(wrEn), .wrData(wrData), .wrRowAddr(wrRowAddr), .wrByteOff(wrByteOff),
    .busy(busy), .done(done),
    .dirtyMinX(dirtyMinX), .dirtyMaxX(dirtyMaxX),
    .dirtyMinY(dirtyMinY), .dirtyMaxY(dirtyMaxY)
  );

  int tests = 0, fails = 0, cyc = 0;
  int wrSeen = 0, doneSeen = 0;
  bit cmpOn = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mRemain, mXs, mYs, mW, mH, mPitch, mRowBytes, mOff, mRow;
  int mWrEn, mWrData, mWrRow, mWrOff, mDone;
  int mMinX, mMaxX, mMinY, mMaxY;

  always @(posedge clk) begin
    if (!rstN) begin
      mRemain = 0; mWrEn = 0; mDone = 0; mWrData = 0; mWrRow = 0; mWrOff = 0;
      mMinX = dispWidth; mMaxX = 0; mMinY = dispHeight; mMaxY = 0;
    end else begin
      int w, h, rb;
      bit ok;
      if (invalidate) begin
        mMinX = 0; mMaxX = dispWidth; mMinY = 0; mMaxY = dispHeight;
      end else begin
        if (refreshAck) begin
          mMinX = dispWidth; mMaxX = 0; mMinY = dispHeight; mMaxY = 0;
        end
        if (mDone != 0) begin
          if (mXs < mMinX) mMinX = mXs;
          if (mXs + mW > mMaxX) mMaxX = mXs + mW;
          if (mYs < mMinY) mMinY = mYs;
          if (mYs + mH > mMaxY) mMaxY = mYs + mH;
        end
      end
      mDone = 0; mWrEn = 0;
      w = int'(cfgXEnd) - int'(cfgXStart) + 1;
      h = int'(cfgYEnd) - int'(cfgYStart) + 1;
      rb = int'(cfgBpp) * w;
      ok = (cfgSource <= 3) && (cfgBpp != 0) && (w >= 1) && (h >= 1) && (rb >= 2);
      if (ok && (srcSelWr || (dataWr && mRemain == 0))) begin
        mRemain = (rb * h) / 2;
        mXs = cfgXStart; mYs = cfgYStart; mW = w; mH = h;
        mPitch = dispWidth; mRowBytes = rb; mOff = 0; mRow = 0;
      end
      if (dataWr && mRemain > 0) begin
        mWrEn = 1; mWrData = dataIn;
        mWrRow = (mYs + mRow) * mPitch + mXs;
        mWrOff = mOff;
        mOff += 2;
        if (mOff >= mRowBytes) begin mOff -= mRowBytes; mRow++; end
        mRemain--;
        if (mRemain == 0) mDone = 1;
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (wrEn) wrSeen++;
    if (done) doneSeen++;
    if (cmpOn) begin
      chk("R5 wrEn", wrEn, mWrEn);
      if (mWrEn != 0) begin
        chk("R5 wrData", wrData, mWrData);
        chk("R5 wrRowAddr", wrRowAddr, mWrRow);
        chk("R5 wrByteOff", wrByteOff, mWrOff);
      end
      chk("R6 done", done, mDone);
      chk("R10 busy", busy, mRemain > 0);
      chk("R7 dirtyMinX", dirtyMinX, mMinX);
      chk("R7 dirtyMaxX", dirtyMaxX, mMaxX);
      chk("R7 dirtyMinY", dirtyMinY, mMinY);
      chk("R7 dirtyMaxY", dirtyMaxY, mMaxY);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=<100000 cycles", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic setWin(input int xs, input int xe, input int ys, input int ye,
                        input int bpp, input int src);
    cfgXStart = xs; cfgXEnd = xe; cfgYStart = ys; cfgYEnd = ye;
    cfgBpp = bpp; cfgSource = src;
  endtask

  task automatic selSrc();
    srcSelWr = 1'b1; @(negedge clk); srcSelWr = 1'b0;
  endtask

  task automatic burst(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      dataWr = 1'b1; dataIn = 16'(base + i * 7); @(negedge clk);
    end
    dataWr = 1'b0;
  endtask

  task automatic dirtyIs(input string req, input int x0, input int x1,
                         input int y0, input int y1);
    chk({req, " minX"}, dirtyMinX, x0);
    chk({req, " maxX"}, dirtyMaxX, x1);
    chk({req, " minY"}, dirtyMinY, y0);
    chk({req, " maxY"}, dirtyMaxY, y1);
  endtask

  initial begin
    int w0, d0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    cmpOn = 1'b1;

    // R1 reset state
    chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 wrEn", wrEn, 0);
    dirtyIs("R1", DISP_W, 0, DISP_H, 0);

    // R3/R4: armed by source select, 2 bpp, 4x2 window -> 8 words
    setWin(3, 6, 2, 3, 2, 1);
    w0 = wrSeen; d0 = doneSeen;
    selSrc();
    chk("R4 busy after select", busy, 1);
    burst(8, 16'h100);
    repeat (2) @(negedge clk);
    chk("R3 words 2bpp", wrSeen - w0, 8);
    chk("R6 one done", doneSeen - d0, 1);
    dirtyIs("R7 first window", 3, 7, 2, 4);

    // R4: armed by first data word; 3 bpp, odd row length (9 bytes) -> 9 words
    setWin(1, 3, 5, 6, 3, 0);
    w0 = wrSeen; d0 = doneSeen;
    burst(9, 16'h200);
    repeat (2) @(negedge clk);
    chk("R4 data-armed words", wrSeen - w0, 9);
    chk("R4 data-armed done", doneSeen - d0, 1);

    // R2: rejections leave the block idle and drop the word
    setWin(0, 3, 0, 0, 0, 0);
    w0 = wrSeen; burst(1, 16'h300); @(negedge clk);
    chk("R2 bpp zero write", wrSeen - w0, 0);
    chk("R2 bpp zero busy", busy, 0);
    setWin(0, 3, 0, 0, 2, 5);
    selSrc(); chk("R2 source busy", busy, 0);
    w0 = wrSeen; burst(1, 16'h301); @(negedge clk);
    chk("R2 source write", wrSeen - w0, 0);
    setWin(5, 4, 0, 0, 2, 0);
    w0 = wrSeen; burst(1, 16'h302); @(negedge clk);
    chk("R2 x reversed", wrSeen - w0, 0);
    setWin(2, 2, 3, 1, 2, 0);
    w0 = wrSeen; burst(1, 16'h303); @(negedge clk);
    chk("R2 y reversed", wrSeen - w0, 0);
    setWin(4, 4, 0, 2, 1, 0);
    w0 = wrSeen; burst(1, 16'h304); @(negedge clk);
    chk("R2 row under 2 bytes", wrSeen - w0, 0);

    // R4: restart discards outstanding words
    setWin(0, 3, 0, 0, 2, 0);
    w0 = wrSeen; d0 = doneSeen;
    selSrc(); burst(2, 16'h400);
    setWin(10, 11, 6, 7, 2, 2);
    selSrc(); burst(4, 16'h500);
    repeat (2) @(negedge clk);
    chk("R4 restart writes", wrSeen - w0, 6);
    chk("R4 restart done", doneSeen - d0, 1);

    // R8: refresh alone empties
    refreshAck = 1'b1; @(negedge clk); refreshAck = 1'b0;
    dirtyIs("R8 empty", DISP_W, 0, DISP_H, 0);

    // R8: refresh in the done cycle keeps that window only
    setWin(8, 9, 5, 5, 2, 0);
    selSrc(); burst(1, 16'h600);
    dataWr = 1'b1; dataIn = 16'h601; @(negedge clk); dataWr = 1'b0;
    chk("R6 done with last", done, 1);
    refreshAck = 1'b1; @(negedge clk); refreshAck = 1'b0;
    dirtyIs("R8 merge into empty", 8, 10, 5, 6);

    // R9: invalidate covers the display
    invalidate = 1'b1; @(negedge clk); invalidate = 1'b0;
    dirtyIs("R9 full", 0, DISP_W, 0, DISP_H);

    // R9: invalidate wins over refresh
    refreshAck = 1'b1; invalidate = 1'b1; @(negedge clk);
    refreshAck = 1'b0; invalidate = 1'b0;
    dirtyIs("R9 over refresh", 0, DISP_W, 0, DISP_H);

    // R3: whole display, 4 bpp -> 256 words
    refreshAck = 1'b1; @(negedge clk); refreshAck = 1'b0;
    setWin(0, DISP_W - 1, 0, DISP_H - 1, 4, 3);
    w0 = wrSeen;
    selSrc(); burst(256, 16'h1000);
    repeat (2) @(negedge clk);
    chk("R3 words 4bpp", wrSeen - w0, 256);
    dirtyIs("R7 full window", 0, DISP_W, 0, DISP_H);

    // R3: odd byte total truncates (3 bpp, 1x3 -> 4 words)
    setWin(15, 15, 0, 2, 3, 0);
    w0 = wrSeen; d0 = doneSeen;
    selSrc(); burst(4, 16'h2000);
    repeat (2) @(negedge clk);
    chk("R3 truncated words", wrSeen - w0, 4);
    chk("R3 truncated done", doneSeen - d0, 1);
    chk("R10 idle after", busy, 0);

    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule